// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block models the command logic of a byte-wide NOR flash. Bus write cycles carry an address and a data byte on a single write strobe. The block turns unlock-and-command sequences into embedded operations on a small on-chip array. Three operations are recognised: program one byte, erase one or more 64 KB sectors, and erase the whole chip. The logical address space is 21 bits wide and is split into 32 sectors by the top five bits. Each sector keeps only `2**KEEP_W` physical bytes, selected by the low address bits, so the model stays small.

An operation starts once its last write cycle has been accepted. While it runs, the busy output is high, further writes are ignored, and reads of the affected locations return a status byte instead of array data. In the status byte, bit 7 is the complement of the final bit 7 of the data being written, and bit 6 flips on every status read. Each operation lasts a fixed number of clock cycles, set by a parameter. A synchronous reset returns the command logic to read mode at any time and abandons any unfinished operation.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: The program sequence is four accepted writes: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the data at the target address. Only address bits 14:0 take part in the unlock address comparison.
- R2: A program can only clear bits. When it completes, the addressed byte holds its previous value AND the written data.
- R3: The sector erase sequence is six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address in the sector. The sector is addr[20:16]. When the erase completes, every byte of that sector reads FFh and all other sectors keep their contents.
- R4: If the sixth write is 10h at 5555h, every byte of the array reads FFh when the erase completes.
- R5: Each further 30h write during the first WIN_CYC busy cycles of a sector erase adds the sector of its address to the set being erased. Writes with other data in that window have no effect.
- R6: busy rises in the cycle after the final command write and stays high for PROG_CYC cycles for a program, WIN_CYC+ERASE_CYC cycles for a sector erase, and ERASE_CYC cycles for a chip erase. Writes made while busy is high do not start or change any operation.
- R7: While busy, a read of a location under operation returns {~D7, T, 000000b}. D7 is bit 7 of the program data (1 for an erase). T is 0 on the first status read of an operation and inverts on each following status read. During a program, every read counts as a location under operation.
- R8: During a sector erase, reads of sectors outside the erase set return array data.
- R9: A write that does not match the next step of a sequence returns the decoder to read mode. The following writes are not taken as the rest of that sequence, and the array is unchanged.
- R10: A synchronous reset clears busy and rdata in the following cycle and returns the decoder to read mode. An operation in progress is abandoned and leaves the array unchanged.
- R11: rdata is registered. It updates one cycle after a read strobe and holds its value while rd is low.
- R12: A read sampled on the last busy cycle of an operation returns status. A read on the following cycle returns the new array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to read mode |
| we | input | 1 | Write strobe; one accepted write cycle per high clock cycle |
| rd | input | 1 | Read strobe |
| addr | input | 21 | Byte address for reads and writes |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High while an embedded operation runs |

## Verification
A status read and the commit of an operation can fall on the same clock edge. The bench provokes this with back-to-back reads issued right after the final program write. Exactly PROG_CYC reads must return status with bit 6 alternating, and the next read must return the ANDed byte. In the same way, a complete program sequence is written into the busy window and must leave the array untouched. The erase window is opened with extra 30h writes and one non-30h write, and only the named sectors may change.

// File: rtl/nor_pkg.sv
package nor_pkg;

    localparam int ADDR_W = 21;
    localparam int SECT_W = 5;
    localparam int NSECT  = 1 << SECT_W;
    localparam int CMP_W  = 15;

    localparam logic [CMP_W-1:0] UNLOCK_ADR_A = 15'h5555;
    localparam logic [CMP_W-1:0] UNLOCK_ADR_B = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_WHOLE   = 8'h10;
    localparam logic [7:0] OP_SECTOR  = 8'h30;

    typedef enum logic [2:0] {
        DC_IDLE,
        DC_KEY1,
        DC_KEY2,
        DC_PDATA,
        DC_EKEY0,
        DC_EKEY1,
        DC_EKEY2
    } dec_state_t;

    typedef enum logic [1:0] {
        EN_READY,
        EN_WINDOW,
        EN_PROG,
        EN_ERASE
    } eng_state_t;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
    } cmd_t;

    function automatic logic [7:0] status_byte(input logic dq7, input logic tog);
        return {dq7, tog, 6'b0};
    endfunction

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eng_ready,
    input  logic             we,
    input  logic [CMP_W-1:0] adr_low,
    input  logic [7:0]       wdata,
    output cmd_t             cmd
);

    dec_state_t st, st_n;
    logic at_a, at_b;

    assign at_a = (adr_low == UNLOCK_ADR_A);
    assign at_b = (adr_low == UNLOCK_ADR_B);

    always_comb begin
        st_n = st;
        cmd  = '0;
        if (!eng_ready) begin
            st_n = DC_IDLE;
        end else if (we) begin
            st_n = DC_IDLE;
            case (st)
                DC_IDLE:  if (at_a && wdata == KEY_FIRST)  st_n = DC_KEY1;
                DC_KEY1:  if (at_b && wdata == KEY_SECOND) st_n = DC_KEY2;
                DC_KEY2: begin
                    if (at_a && wdata == OP_PROGRAM)    st_n = DC_PDATA;
                    else if (at_a && wdata == OP_ERASE) st_n = DC_EKEY0;
                end
                DC_PDATA: cmd.prog = 1'b1;
                DC_EKEY0: if (at_a && wdata == KEY_FIRST)  st_n = DC_EKEY1;
                DC_EKEY1: if (at_b && wdata == KEY_SECOND) st_n = DC_EKEY2;
                DC_EKEY2: begin
                    if (at_a && wdata == OP_WHOLE)  cmd.chip = 1'b1;
                    else if (wdata == OP_SECTOR)    cmd.sect = 1'b1;
                end
                default:  st_n = DC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= DC_IDLE;
        else     st <= st_n;
    end

    AST_CMD_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        (cmd.prog || cmd.chip || cmd.sect) |-> (we && eng_ready)) else $error("cmd"); // R6

endmodule

// File: rtl/nor_embed_engine.sv
module nor_embed_engine
    import nor_pkg::*;
#(
    parameter int KEEP_W    = 2,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64,
    parameter int WIN_CYC   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SECT_W-1:0] wr_sect,
    input  logic [KEEP_W-1:0] wr_off,
    input  logic [7:0]        wdata,
    input  cmd_t              cmd,
    output logic              busy,
    output logic              ready,
    output logic              is_prog,
    output logic              op_start,
    output logic [NSECT-1:0]  erase_mask,
    output logic              dq7_status,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic [SECT_W-1:0] pa_sect,
    output logic [KEEP_W-1:0] pa_off,
    output logic [7:0]        pa_data
);

    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ?
                           ((PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC) :
                           ((ERASE_CYC > WIN_CYC) ? ERASE_CYC : WIN_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    eng_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero     = (cnt == '0);
    assign busy         = (st != EN_READY);
    assign ready        = (st == EN_READY);
    assign is_prog      = (st == EN_PROG);
    assign op_start     = ready && (cmd.prog || cmd.chip || cmd.sect);
    assign dq7_status   = is_prog ? ~pa_data[7] : 1'b0;
    assign commit_prog  = is_prog && cnt_zero;
    assign commit_erase = (st == EN_ERASE) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= EN_READY;
            cnt        <= '0;
            erase_mask <= '0;
            pa_sect    <= '0;
            pa_off     <= '0;
            pa_data    <= '0;
        end else begin
            case (st)
                EN_READY: begin
                    if (cmd.prog) begin
                        st      <= EN_PROG;
                        cnt     <= CNT_W'(PROG_CYC - 1);
                        pa_sect <= wr_sect;
                        pa_off  <= wr_off;
                        pa_data <= wdata;
                    end else if (cmd.chip) begin
                        st         <= EN_ERASE;
                        cnt        <= CNT_W'(ERASE_CYC - 1);
                        erase_mask <= '1;
                    end else if (cmd.sect) begin
                        st                  <= EN_WINDOW;
                        cnt                 <= CNT_W'(WIN_CYC - 1);
                        erase_mask          <= '0;
                        erase_mask[wr_sect] <= 1'b1;
                    end
                end
                EN_WINDOW: begin
                    if (we && wdata == OP_SECTOR) erase_mask[wr_sect] <= 1'b1;
                    if (cnt_zero) begin
                        st  <= EN_ERASE;
                        cnt <= CNT_W'(ERASE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt_zero) begin
                        st         <= EN_READY;
                        erase_mask <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(we)) else $error("busy rose without write"); // R6
    AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (commit_prog || commit_erase) |=> !busy) else $error("busy after commit"); // R6
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st == EN_ERASE && $past(st) == EN_ERASE) |-> $stable(erase_mask)) else $error("mask"); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !busy) else $error("busy after reset"); // R10

endmodule

// File: rtl/nor_sector_bank.sv
module nor_sector_bank #(
    parameter int KEEP_W = 2
) (
    input  logic              clk,
    input  logic              erase_en,
    input  logic              prog_en,
    input  logic [KEEP_W-1:0] prog_off,
    input  logic [7:0]        prog_data,
    input  logic [KEEP_W-1:0] rd_off,
    output logic [7:0]        rd_byte
);

    localparam int DEPTH = 1 << KEEP_W;

    logic [7:0] cells [DEPTH];

    assign rd_byte = cells[rd_off];

    always_ff @(posedge clk) begin
        if (erase_en) begin
            for (int j = 0; j < DEPTH; j++) cells[j] <= 8'hFF;
        end else if (prog_en) begin
            cells[prog_off] <= cells[prog_off] & prog_data;
        end
    end

endmodule

// File: rtl/nor_array_store.sv
module nor_array_store
    import nor_pkg::*;
#(
    parameter int KEEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [KEEP_W-1:0] rd_off,
    input  logic              busy,
    input  logic              is_prog,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic              dq7_status,
    input  logic              op_start,
    input  logic              commit_prog,
    input  logic              commit_erase,
    input  logic [SECT_W-1:0] pa_sect,
    input  logic [KEEP_W-1:0] pa_off,
    input  logic [7:0]        pa_data,
    output logic [7:0]        rdata
);

    logic [7:0] bank_q [NSECT];
    logic       tog;
    logic       show_status;

    for (genvar g = 0; g < NSECT; g++) begin : g_bank
        nor_sector_bank #(.KEEP_W(KEEP_W)) u_bank (
            .clk       (clk),
            .erase_en  (commit_erase && erase_mask[g]),
            .prog_en   (commit_prog && (pa_sect == SECT_W'(g))),
            .prog_off  (pa_off),
            .prog_data (pa_data),
            .rd_off    (rd_off),
            .rd_byte   (bank_q[g])
        );
    end

    assign show_status = busy && (is_prog || erase_mask[rd_sect]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else begin
            if (op_start) tog <= 1'b0;
            if (rd) begin
                if (show_status) begin
                    rdata <= status_byte(dq7_status, tog);
                    tog   <= ~tog;
                end else begin
                    rdata <= bank_q[rd_sect];
                end
            end
        end
    end

    AST_TOGGLE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (rd && show_status && $past(rd && show_status)) |=> (rdata[6] != $past(rdata[6])))
        else $error("toggle"); // R7
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata)) else $error("rdata moved"); // R11

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_pkg::*;
#(
    parameter int KEEP_W    = 2,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64,
    parameter int WIN_CYC   = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic        rd,
    input  logic [20:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        busy
);

    cmd_t              cmd;
    logic              ready, is_prog, op_start, dq7_status;
    logic              commit_prog, commit_erase;
    logic [NSECT-1:0]  erase_mask;
    logic [SECT_W-1:0] pa_sect;
    logic [KEEP_W-1:0] pa_off;
    logic [7:0]        pa_data;
    logic              unused_addr15;

    assign unused_addr15 = addr[15];

    nor_cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .eng_ready (ready),
        .we        (we),
        .adr_low   (addr[CMP_W-1:0]),
        .wdata     (wdata),
        .cmd       (cmd)
    );

    nor_embed_engine #(
        .KEEP_W    (KEEP_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .WIN_CYC   (WIN_CYC)
    ) u_eng (
        .clk          (clk),
        .rst          (rst),
        .we           (we),
        .wr_sect      (addr[ADDR_W-1 -: SECT_W]),
        .wr_off       (addr[KEEP_W-1:0]),
        .wdata        (wdata),
        .cmd          (cmd),
        .busy         (busy),
        .ready        (ready),
        .is_prog      (is_prog),
        .op_start     (op_start),
        .erase_mask   (erase_mask),
        .dq7_status   (dq7_status),
        .commit_prog  (commit_prog),
        .commit_erase (commit_erase),
        .pa_sect      (pa_sect),
        .pa_off       (pa_off),
        .pa_data      (pa_data)
    );

    nor_array_store #(.KEEP_W(KEEP_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .rd           (rd),
        .rd_sect      (addr[ADDR_W-1 -: SECT_W]),
        .rd_off       (addr[KEEP_W-1:0]),
        .busy         (busy),
        .is_prog      (is_prog),
        .erase_mask   (erase_mask),
        .dq7_status   (dq7_status),
        .op_start     (op_start),
        .commit_prog  (commit_prog),
        .commit_erase (commit_erase),
        .pa_sect      (pa_sect),
        .pa_off       (pa_off),
        .pa_data      (pa_data),
        .rdata        (rdata)
    );

endmodule

// File: tb/tb_nor_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_nor_cmd_ctrl;

    localparam int KW = 2;
    localparam int PC = 4;
    localparam int EC = 6;
    localparam int WC = 8;
    localparam int NSLOT = 32 << KW;

    logic        clk = 1'b0;
    logic        rst, we, rd;
    logic [20:0] addr;
    logic [7:0]  wdata, rdata;
    logic        busy;

    always #2 clk = ~clk;

    nor_cmd_ctrl #(.KEEP_W(KW), .PROG_CYC(PC), .ERASE_CYC(EC), .WIN_CYC(WC)) dut (
        .clk(clk), .rst(rst), .we(we), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] mdl [NSLOT];
    logic tog;

    function automatic logic [20:0] slot_addr(input int i, input logic [13:0] mid);
        return {5'(i >> KW), mid, 2'(i)};
    endfunction

    function automatic int ix(input logic [20:0] a);
        return int'({a[20:16], a[1:0]});
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_get(input logic [20:0] a, output logic [7:0] q);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        q = rdata;
    endtask

    task automatic rd_chk(input logic [20:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] q;
        rd_get(a, q);
        chk(q == exp, tag, q, exp);
    endtask

    task automatic prog(input logic [20:0] a, input logic [7:0] d);
        wr(21'h05555, 8'hAA);
        wr(21'h02AAA, 8'h55);
        wr(21'h05555, 8'hA0);
        tog = 1'b0;
        wr(a, d);
    endtask

    task automatic erase_cmd(input logic [20:0] a, input logic [7:0] d);
        wr(21'h05555, 8'hAA);
        wr(21'h02AAA, 8'h55);
        wr(21'h05555, 8'h80);
        wr(21'h05555, 8'hAA);
        wr(21'h02AAA, 8'h55);
        tog = 1'b0;
        wr(a, d);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < NSLOT; i++) rd_chk(slot_addr(i, 14'h0), mdl[i], tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] q, q2;
        rst = 1'b1; we = 1'b0; rd = 1'b0; addr = '0; wdata = '0; tog = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(rdata == 8'h00, "R10 reset rdata", rdata, 0);
        rst = 1'b0;
        @(negedge clk);

        // R4 chip erase and its busy length
        erase_cmd(21'h05555, 8'h10);
        wait_idle(n);
        chk(n == EC, "R6 chip erase busy cycles", n, EC);
        for (int i = 0; i < NSLOT; i++) mdl[i] = 8'hFF;
        chk_all("R4 chip erase all FF");

        // R1 program sweep over every stored byte, with varied middle address bits
        for (int i = 0; i < NSLOT; i++) begin
            logic [7:0] d;
            d = 8'((i * 29 + 7) & 255);
            prog(slot_addr(i, 14'((i * 613) & 16383)), d);
            wait_idle(n);
            if (i == 0) chk(n == PC, "R6 program busy cycles", n, PC);
            mdl[i] = mdl[i] & d;
        end
        chk_all("R1 program sweep");

        // R2 AND semantics
        prog(slot_addr(5, 14'h0), 8'hF0); wait_idle(n);
        mdl[5] = mdl[5] & 8'hF0;
        rd_chk(slot_addr(5, 14'h0), mdl[5], "R2 program ANDs");
        prog(slot_addr(5, 14'h0), 8'hFF); wait_idle(n);
        rd_chk(slot_addr(5, 14'h0), mdl[5], "R2 program cannot set bits");

        // R7 / R12 status reads up to and across completion
        prog(slot_addr(9, 14'h0), 8'h3C);
        for (int k = 0; k < PC; k++) begin
            rd_chk(slot_addr(9, 14'h0), {1'b1, tog, 6'b0}, "R7 R12 program status");
            tog = ~tog;
        end
        mdl[9] = mdl[9] & 8'h3C;
        rd_chk(slot_addr(9, 14'h0), mdl[9], "R12 data after completion");
        chk(busy == 1'b0, "R6 busy low after program", busy, 0);
        prog(slot_addr(10, 14'h0), 8'h81);
        rd_chk(slot_addr(77, 14'h0), {1'b0, 1'b0, 6'b0}, "R7 any read is status, dq7=0");
        rd_chk(slot_addr(77, 14'h0), {1'b0, 1'b1, 6'b0}, "R7 toggle second read");
        wait_idle(n);
        mdl[10] = mdl[10] & 8'h81;
        rd_chk(slot_addr(10, 14'h0), mdl[10], "R7 program completed");

        // R9 broken sequences
        wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'h77);
        wr(slot_addr(12, 14'h0), 8'h00);
        chk(busy == 1'b0, "R9 bad command no busy", busy, 0);
        rd_chk(slot_addr(12, 14'h0), mdl[12], "R9 bad command array unchanged");
        wr(21'h05555, 8'hAA); wr(21'h01111, 8'h55); wr(21'h05555, 8'hA0);
        wr(slot_addr(13, 14'h0), 8'h00);
        chk(busy == 1'b0, "R9 bad unlock no busy", busy, 0);
        rd_chk(slot_addr(13, 14'h0), mdl[13], "R9 bad unlock array unchanged");
        prog(slot_addr(13, 14'h0), 8'h0F); wait_idle(n);
        mdl[13] = mdl[13] & 8'h0F;
        rd_chk(slot_addr(13, 14'h0), mdl[13], "R9 recovery after break");

        // R6 writes during busy are ignored
        prog(slot_addr(14, 14'h0), 8'hFE);
        prog(slot_addr(15, 14'h0), 8'h00);
        wait_idle(n);
        mdl[14] = mdl[14] & 8'hFE;
        rd_chk(slot_addr(15, 14'h0), mdl[15], "R6 program during busy ignored");
        rd_chk(slot_addr(14, 14'h0), mdl[14], "R6 first program done");

        // R10 reset mid operation and mid sequence
        prog(slot_addr(16, 14'h0), 8'h00);
        @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk(busy == 1'b0, "R10 reset clears busy", busy, 0);
        rd_chk(slot_addr(16, 14'h0), mdl[16], "R10 aborted program leaves array");
        wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        wr(21'h05555, 8'hA0); wr(slot_addr(16, 14'h0), 8'h00);
        chk(busy == 1'b0, "R10 reset clears sequence", busy, 0);
        rd_chk(slot_addr(16, 14'h0), mdl[16], "R10 sequence reset array unchanged");

        // R1 unlock compares only address bits 14:0
        wr(21'h1F5555, 8'hAA); wr(21'h0AAAAA, 8'h55); wr(21'h155555, 8'hA0);
        wr(slot_addr(17, 14'h0), 8'h70);
        wait_idle(n);
        mdl[17] = mdl[17] & 8'h70;
        rd_chk(slot_addr(17, 14'h0), mdl[17], "R1 unlock high bits ignored");

        // R11 rdata holds
        rd_get(slot_addr(17, 14'h0), q);
        repeat (3) @(negedge clk);
        chk(rdata == q, "R11 rdata holds without rd", rdata, q);

        // R3 sector erase sweep
        for (int s = 0; s < 32; s++) begin
            erase_cmd({5'(s), 16'h0123}, 8'h30);
            wait_idle(n);
            if (s == 0) chk(n == WC + EC, "R6 sector erase busy cycles", n, WC + EC);
            for (int j = 0; j < (1 << KW); j++) mdl[(s << KW) + j] = 8'hFF;
            chk_all("R3 sector erase sweep");
        end

        // R5 erase window collects extra sectors
        prog(slot_addr(2 << KW, 14'h0), 8'h11);  wait_idle(n);
        prog(slot_addr(3 << KW, 14'h0), 8'h22);  wait_idle(n);
        prog(slot_addr(7 << KW, 14'h0), 8'h33);  wait_idle(n);
        prog(slot_addr(20 << KW, 14'h0), 8'h44); wait_idle(n);
        erase_cmd({5'd3, 16'h0000}, 8'h30);
        wr({5'd7, 16'h4000}, 8'h30);
        wr({5'd20, 16'h0001}, 8'h30);
        wr({5'd2, 16'h0000}, 8'h55);
        wait_idle(n);
        chk(n == WC + EC - 3, "R5 window busy length", n, WC + EC - 3);
        rd_chk(slot_addr(2 << KW, 14'h0), 8'h11, "R5 non-30h write ignored");
        rd_chk(slot_addr(3 << KW, 14'h0), 8'hFF, "R5 first sector erased");
        rd_chk(slot_addr(7 << KW, 14'h0), 8'hFF, "R5 added sector erased");
        rd_chk(slot_addr(20 << KW, 14'h0), 8'hFF, "R5 second added sector erased");

        // R8 reads of other sectors during erase
        prog(slot_addr((5 << KW) + 1, 14'h0), 8'h42); wait_idle(n);
        prog(slot_addr((6 << KW) + 2, 14'h0), 8'h24); wait_idle(n);
        erase_cmd({5'd5, 16'h0000}, 8'h30);
        rd_chk(slot_addr((6 << KW) + 2, 14'h0), 8'h24, "R8 other sector reads data");
        rd_chk(slot_addr((5 << KW) + 1, 14'h0), 8'h00, "R7 erase status first");
        rd_chk(slot_addr((5 << KW) + 1, 14'h0), 8'h40, "R7 erase status toggled");
        wait_idle(n);
        rd_get(slot_addr((5 << KW) + 1, 14'h0), q);
        rd_get(slot_addr((6 << KW) + 2, 14'h0), q2);
        chk(q == 8'hFF, "R3 erased sector after R8 test", q, 8'hFF);
        chk(q2 == 8'h24, "R8 other sector kept", q2, 8'h24);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule